// File: doc/BRIEF.md
# Hot-Plug Indicator Message Decoder

This block sits behind the receive path of a PCI Express endpoint. It watches the messages that have already been parsed out of the link. Each message arrives as an 8-bit message code and a 3-bit routing field, qualified by a one-cycle valid strobe. Six codes request a change to the attention indicator or the power indicator. Each of these six codes latches its own sticky status flag. All other codes, and any message that is not routed to the local receiver, leave the block untouched.

Software owns two small registers through a single write port. The flag register is write-one-to-clear. The enable register is loaded whole. The interrupt request is the OR of every flag gated by its enable bit, so it stays high until software clears the flags behind it. When a message sets a flag in the same cycle that software clears it, the message wins, so no event is lost.

Top module: `hpd_msg_decoder`

## Requirements
- R1: After reset, status_o and enable_o are all zero and irq_o is low.
- R2: A message is acted on only when msg_route equals 3'b100. Any other routing value leaves status_o unchanged.
- R3: With routing 3'b100, the attention codes set one status_o bit each: 8'h41 sets bit 0 (on), 8'h43 sets bit 1 (blink) and 8'h40 sets bit 2 (off). The bit is visible one clock after the strobe.
- R4: With routing 3'b100, the power codes set one status_o bit each: 8'h45 sets bit 3 (on), 8'h47 sets bit 4 (blink) and 8'h44 sets bit 5 (off).
- R5: Codes 8'h48 and 8'h7F, and every code not listed in R3 or R4, change no status bit.
- R6: Status bits are sticky. A set bit stays set until it is cleared by software, whatever messages follow.
- R7: A write with cfg_wr=1 and cfg_sel=0 clears every status bit whose cfg_wdata bit is 1. Bits whose cfg_wdata bit is 0 are left as they are.
- R8: When a message sets a bit in the same cycle that a status write clears it, the bit ends up set.
- R9: A write with cfg_wr=1 and cfg_sel=1 loads cfg_wdata into enable_o on the next clock. A status write does not change enable_o.
- R10: irq_o is high exactly when some bit is set in both status_o and enable_o. It follows those registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Strobe qualifying one received message |
| msg_code | input | 8 | Message code |
| msg_route | input | 3 | Message routing field |
| cfg_wr | input | 1 | Software write strobe |
| cfg_sel | input | 1 | Write target: 0 status (write-one-to-clear), 1 enable |
| cfg_wdata | input | 6 | Write data, one bit per event |
| status_o | output | 6 | Sticky event flags |
| enable_o | output | 6 | Per-event interrupt enables |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume two things about the inputs: a message strobe lasts one cycle per message, and the write strobe is low whenever a property claims that status holds. The properties for routing and stickiness are therefore conditioned on the absence of a status write. The stimulus raises each strobe for exactly one cycle, driven on the falling edge. It keeps writes and messages in separate cycles everywhere except the one deliberate collision that exercises R8. The sweep covers all 256 codes under all eight routing values, with an enable pattern that varies from vector to vector.

// File: rtl/hpd_pkg.sv
package hpd_pkg;

   localparam int HPD_NEVT   = 6;
   localparam int HPD_CODE_W = 8;
   localparam int HPD_RTE_W  = 3;

   typedef enum int {
      EV_ATTN_ON    = 0,
      EV_ATTN_BLINK = 1,
      EV_ATTN_OFF   = 2,
      EV_PWR_ON     = 3,
      EV_PWR_BLINK  = 4,
      EV_PWR_OFF    = 5
   } hpd_evt_e;

   typedef logic [HPD_NEVT-1:0] hpd_vec_t;

   // code that raises the flag at a given event position
   function automatic logic [HPD_CODE_W-1:0] hpd_code_of(input int idx);
      case (idx)
         EV_ATTN_ON:    hpd_code_of = 8'h41;
         EV_ATTN_BLINK: hpd_code_of = 8'h43;
         EV_ATTN_OFF:   hpd_code_of = 8'h40;
         EV_PWR_ON:     hpd_code_of = 8'h45;
         EV_PWR_BLINK:  hpd_code_of = 8'h47;
         EV_PWR_OFF:    hpd_code_of = 8'h44;
         default:       hpd_code_of = 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/hpd_code_match.sv
module hpd_code_match
   import hpd_pkg::*;
#(
   parameter int                  CODE_W      = HPD_CODE_W,
   parameter int                  RTE_W       = HPD_RTE_W,
   parameter int                  NEVT        = HPD_NEVT,
   parameter logic [RTE_W-1:0]    ROUTE_LOCAL = 3'b100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              msg_valid,
   input  logic [CODE_W-1:0] msg_code,
   input  logic [RTE_W-1:0]  msg_route,
   output logic [NEVT-1:0]   evt_set
);

   if (CODE_W != HPD_CODE_W) begin : g_bad_code_w
      $error("hpd_code_match: CODE_W must equal the package code width");
   end
   if (NEVT != HPD_NEVT) begin : g_bad_nevt
      $error("hpd_code_match: NEVT must equal the package event count");
   end

   logic              route_ok;
   logic [NEVT-1:0]   code_hit;

   assign route_ok = msg_valid && (msg_route == ROUTE_LOCAL);

   for (genvar i = 0; i < NEVT; i++) begin : g_cmp
      localparam logic [CODE_W-1:0] MATCH = hpd_code_of(i);
      assign code_hit[i] = (msg_code == MATCH);
   end

   assign evt_set = route_ok ? code_hit : '0;

   // R3 R4: the code table is distinct, so at most one event fires
   p_set_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(evt_set));

   // R5: the ignored codes never produce an event
   p_ignored_codes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_code == 8'h48 || msg_code == 8'h7F) |-> (evt_set == '0));

   // R2: no event without the local routing value
   p_route_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_route != ROUTE_LOCAL) |-> (evt_set == '0));

endmodule

// File: rtl/hpd_sticky_bank.sv
module hpd_sticky_bank #(
   parameter int NEVT = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NEVT-1:0] set_vec,
   input  logic [NEVT-1:0] clr_vec,
   input  logic            en_load,
   input  logic [NEVT-1:0] en_data,
   output logic [NEVT-1:0] status_q,
   output logic [NEVT-1:0] enable_q
);

   if (NEVT < 1) begin : g_bad_nevt
      $error("hpd_sticky_bank: NEVT must be at least 1");
   end

   for (genvar i = 0; i < NEVT; i++) begin : g_cell
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            status_q[i] <= 1'b0;
         end else if (set_vec[i]) begin
            status_q[i] <= 1'b1;
         end else if (clr_vec[i]) begin
            status_q[i] <= 1'b0;
         end
      end

      // R8: a collision leaves the bit set
      p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (set_vec[i] && clr_vec[i]) |=> status_q[i]);

      // R6: without a clear, a set bit holds
      p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (status_q[i] && !clr_vec[i]) |=> status_q[i]);

      // R7: a clear without a set empties the bit
      p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_vec[i] && !set_vec[i]) |=> !status_q[i]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable_q <= '0;
      end else if (en_load) begin
         enable_q <= en_data;
      end
   end

   // R9: enable load takes effect next cycle, otherwise holds
   p_enable_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      en_load |=> (enable_q == $past(en_data)));
   p_enable_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en_load |=> $stable(enable_q));

endmodule

// File: rtl/hpd_irq_merge.sv
module hpd_irq_merge #(
   parameter int NEVT = 6
) (
   input  logic [NEVT-1:0] status,
   input  logic [NEVT-1:0] enable,
   output logic            irq
);

   logic [NEVT:0] chain;

   assign chain[0] = 1'b0;
   for (genvar i = 0; i < NEVT; i++) begin : g_or
      assign chain[i+1] = chain[i] | (status[i] & enable[i]);
   end

   assign irq = chain[NEVT];

endmodule

// File: rtl/hpd_msg_decoder.sv
module hpd_msg_decoder
   import hpd_pkg::*;
#(
   parameter logic [HPD_RTE_W-1:0] ROUTE_LOCAL = 3'b100
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  msg_valid,
   input  logic [HPD_CODE_W-1:0] msg_code,
   input  logic [HPD_RTE_W-1:0]  msg_route,
   input  logic                  cfg_wr,
   input  logic                  cfg_sel,
   input  logic [HPD_NEVT-1:0]   cfg_wdata,
   output logic [HPD_NEVT-1:0]   status_o,
   output logic [HPD_NEVT-1:0]   enable_o,
   output logic                  irq_o
);

   localparam int NEVT = HPD_NEVT;

   logic [NEVT-1:0] evt_set;
   logic [NEVT-1:0] clr_vec;
   logic            en_load;

   assign clr_vec = (cfg_wr && !cfg_sel) ? cfg_wdata : '0;
   assign en_load = cfg_wr && cfg_sel;

   hpd_code_match #(
      .CODE_W      (HPD_CODE_W),
      .RTE_W       (HPD_RTE_W),
      .NEVT        (NEVT),
      .ROUTE_LOCAL (ROUTE_LOCAL)
   ) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .msg_valid (msg_valid),
      .msg_code  (msg_code),
      .msg_route (msg_route),
      .evt_set   (evt_set)
   );

   hpd_sticky_bank #(.NEVT(NEVT)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vec  (evt_set),
      .clr_vec  (clr_vec),
      .en_load  (en_load),
      .en_data  (cfg_wdata),
      .status_q (status_o),
      .enable_q (enable_o)
   );

   hpd_irq_merge #(.NEVT(NEVT)) u_irq (
      .status (status_o),
      .enable (enable_o),
      .irq    (irq_o)
   );

   // R2: off-route messages leave status alone when software is quiet
   p_route_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_route != ROUTE_LOCAL && !cfg_wr) |=> $stable(status_o));

   // R10: a raised request persists until a write changes the registers
   p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !cfg_wr) |=> irq_o);

   // R10: no request while nothing is enabled
   p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_o == '0) |-> !irq_o);

   // R1: registers leave reset empty
   p_reset_r1: assert property (@(posedge clk)
      !rst_n |=> (status_o == '0 && enable_o == '0));

endmodule

// File: tb/hpd_msg_decoder_bench.sv
module hpd_msg_decoder_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       msg_valid = 1'b0;
   logic [7:0] msg_code = '0;
   logic [2:0] msg_route = '0;
   logic       cfg_wr = 1'b0;
   logic       cfg_sel = 1'b0;
   logic [5:0] cfg_wdata = '0;
   logic [5:0] status_o;
   logic [5:0] enable_o;
   logic       irq_o;

   int n_vec = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   hpd_msg_decoder u_hpd_msg_decoder (
      .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_code(msg_code),
      .msg_route(msg_route), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .status_o(status_o), .enable_o(enable_o),
      .irq_o(irq_o)
   );

   function automatic int exp_bit(input logic [7:0] c);
      case (c)
         8'h41: exp_bit = 0;
         8'h43: exp_bit = 1;
         8'h40: exp_bit = 2;
         8'h45: exp_bit = 3;
         8'h47: exp_bit = 4;
         8'h44: exp_bit = 5;
         default: exp_bit = -1;
      endcase
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] c, input logic [2:0] r);
      @(negedge clk);
      msg_valid = 1'b1; msg_code = c; msg_route = r;
      @(negedge clk);
      msg_valid = 1'b0;
   endtask

   task automatic wr(input logic sel, input logic [5:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   initial begin
      #1500000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [5:0] exp_st;
      logic [5:0] en;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 status", {2'b0, status_o}, 8'h00);
      check("R1 enable", {2'b0, enable_o}, 8'h00);
      check("R1 irq", {7'b0, irq_o}, 8'h00);
      rst_n = 1'b1;

      // R2 R3 R4 R5 R10: sweep of every code under every routing value
      for (int r = 0; r < 8; r++) begin
         for (int c = 0; c < 256; c++) begin
            en = 6'(c ^ (r * 9));
            wr(1'b0, 6'h3F);
            wr(1'b1, en);
            send(8'(c), 3'(r));
            exp_st = '0;
            if (r == 4 && exp_bit(8'(c)) >= 0) exp_st[exp_bit(8'(c))] = 1'b1;
            check((r == 4) ? "R3 R4 R5 status" : "R2 status", {2'b0, status_o}, {2'b0, exp_st});
            check("R9 enable", {2'b0, enable_o}, {2'b0, en});
            check("R10 irq", {7'b0, irq_o}, {7'b0, |(exp_st & en)});
         end
      end

      // R6 sticky across several messages, R7 partial clear
      wr(1'b0, 6'h3F);
      wr(1'b1, 6'h00);
      send(8'h41, 3'b100);
      send(8'h47, 3'b100);
      send(8'h48, 3'b100);
      send(8'h7F, 3'b100);
      send(8'h44, 3'b011);
      check("R6 sticky", {2'b0, status_o}, 8'h11);
      check("R10 masked", {7'b0, irq_o}, 8'h00);
      wr(1'b1, 6'h10);
      check("R10 irq on", {7'b0, irq_o}, 8'h01);
      wr(1'b0, 6'h0E);
      check("R7 zeros keep", {2'b0, status_o}, 8'h11);
      check("R9 status write keeps enable", {2'b0, enable_o}, 8'h10);
      wr(1'b0, 6'h10);
      check("R7 clear", {2'b0, status_o}, 8'h01);
      check("R10 irq drop", {7'b0, irq_o}, 8'h00);

      // R8 collision: message and clear in the same cycle
      @(negedge clk);
      msg_valid = 1'b1; msg_code = 8'h43; msg_route = 3'b100;
      cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = 6'h03;
      @(negedge clk);
      msg_valid = 1'b0; cfg_wr = 1'b0;
      check("R8 set wins", {2'b0, status_o}, 8'h02);

      // R1 reset mid-run
      wr(1'b1, 6'h3F);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check("R1 re-reset status", {2'b0, status_o}, 8'h00);
      check("R1 re-reset enable", {2'b0, enable_o}, 8'h00);
      rst_n = 1'b1;

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule